// File: doc/BRIEF.md
# Configurable byte-wide SPI master with register access

This block moves one byte at a time over a four-wire serial link as the clock-owning side. Software talks to it through four byte-wide registers selected by a two-bit address. One register reports progress and completion. One sets the clock idle level, the capture edge, the bit order and a rate exponent. One holds a rate mantissa. One is the data buffer. Writing the data buffer while the block is idle starts a full-duplex exchange. The byte written goes out on MOSI while a byte is gathered from MISO. When the exchange ends, reading the data buffer returns the gathered byte.

The serial clock rate comes from a phase accumulator. Each system clock adds an increment built from the mantissa and the exponent, and each carry out of the accumulator produces one SCK edge. This gives a wide range of rates from a small set of register bits. A completion flag rises when the eighth bit has been exchanged. It stays up until software clears it. Device select lines are not part of this block; software drives them through a general-purpose output elsewhere.

Top module: `spim_top`

## Requirements
- R1: After reset, the STAT, FMT and MANT registers read 0x00, SCK is low and MOSI is low.
- R2: FMT (address 1) and MANT (address 2) read back the last value written. STAT (address 0) reads bit 1 = done and bit 0 = busy, with every other bit 0 whatever was written to them.
- R3: Writing DATA (address 3) while idle sets the busy bit from the next cycle. The exchange makes exactly 16 SCK transitions, and busy clears on the cycle of the 16th transition.
- R4: A 28-bit accumulator, cleared at start, gains min((256 + MANT) * 2^(E+1), 2^28) each busy cycle, where E = FMT[4:0]. Each carry out is one SCK transition. So E=17/MANT=0 gives 64 busy cycles, E=18 gives 32, E=17/MANT=128 gives 43, and E=27 gives one transition per cycle (16 cycles).
- R5: SCK rests at FMT bit 7 (polarity) whenever the block is idle. During an exchange SCK changes only on accumulator carries, and it ends back at the resting level.
- R6: With FMT bit 6 = 0, the first data bit is on MOSI from the start cycle. MISO is captured on the 1st, 3rd, … transitions, and MOSI moves to the next bit on the 2nd, 4th, … 14th transitions.
- R7: With FMT bit 6 = 1, MOSI takes each bit on the 1st, 3rd, … transitions, and MISO is captured on the 2nd, 4th, … 16th transitions.
- R8: With FMT bit 5 = 1, bit 7 of the byte goes first in both directions. With FMT bit 5 = 0, bit 0 goes first.
- R9: STAT bit 1 sets on the cycle busy clears. Writing STAT with bit 1 = 0 clears it, and writing bit 1 = 1 leaves it set. A completion in the same cycle as a clearing write wins.
- R10: A write to DATA while busy is ignored: the byte on MOSI, the timing and the received byte are unchanged.
- R11: After completion, reading DATA returns the byte captured from MISO in the selected bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 STAT, 1 FMT, 2 MANT, 3 DATA |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that software leaves FMT and MANT alone while busy is set. A mid-exchange change of polarity, phase or rate would legally reshape the edge pattern they reason about. They also assume that MISO is settled before each capturing transition. The stimulus writes the format and rate only between exchanges. The emulated slave updates MISO half a clock after each edge, from the bit index of the reference model. The only register traffic during an exchange is status polling and one deliberate DATA write made to exercise the busy lockout.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int ACC_W  = 28;
    localparam int EXP_W  = 5;
    localparam int MANT_W = 8;

    // register select values
    typedef enum logic [AW-1:0] {
        A_STAT = 2'd0,
        A_FMT  = 2'd1,
        A_MANT = 2'd2,
        A_DATA = 2'd3
    } reg_sel_e;

    // field positions inside FMT and STAT
    localparam int F_CPOL = 7;
    localparam int F_CPHA = 6;
    localparam int F_MSB  = 5;
    localparam int S_DONE = 1;
    localparam int S_BUSY = 0;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int ACC_W  = 28,
    parameter int EXP_W  = 5,
    parameter int MANT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    output logic              tick_o
);
    localparam int SH_MAX = (1 << EXP_W);
    localparam int INC_W  = MANT_W + 1 + SH_MAX + 1;
    localparam logic [INC_W-1:0] FULL = INC_W'(1) << ACC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } baud_st_t;

    baud_st_t         st_q, st_d;
    logic [EXP_W:0]   shamt;
    logic [INC_W-1:0] inc_raw;
    logic [ACC_W:0]   inc;
    logic [ACC_W:0]   sum;

    always_comb begin
        shamt   = {1'b0, exp_i} + {{EXP_W{1'b0}}, 1'b1};
        inc_raw = INC_W'({1'b1, mant_i}) << shamt;
        inc     = (inc_raw >= FULL) ? FULL[ACC_W:0] : inc_raw[ACC_W:0];
        sum     = {1'b0, st_q.acc} + inc;
        tick_o  = run_i & sum[ACC_W];
        st_d    = st_q;
        if (clear_i) begin
            st_d.acc = '0;
        end else if (run_i) begin
            st_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a saturated increment must yield an edge on every running cycle
    a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clear_i && inc == FULL[ACC_W:0]) |-> tick_o);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] tx_i,
    input  logic          tick_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          msb_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          busy_o,
    output logic          finish_o,
    output logic [DW-1:0] rx_o
);
    localparam int EDGES = 2 * DW;
    localparam int CNT_W = $clog2(EDGES);
    localparam int BIT_W = CNT_W - 1;

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             mosi;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    tx;
        logic [DW-1:0]    rx;
    } shf_st_t;

    shf_st_t          st_q, st_d;
    logic             lead;
    logic             last;
    logic [BIT_W-1:0] bidx;

    function automatic logic [BIT_W-1:0] bitpos(input logic [BIT_W-1:0] k,
                                                input logic msb);
        bitpos = msb ? (BIT_W'(DW - 1) - k) : k;
    endfunction

    always_comb begin
        st_d     = st_q;
        finish_o = 1'b0;
        lead     = ~st_q.cnt[0];
        last     = (st_q.cnt == CNT_W'(EDGES - 1));
        bidx     = st_q.cnt[CNT_W-1:1];
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.tx   = tx_i;
            st_d.sck  = cpol_i;
            if (!cpha_i) st_d.mosi = tx_i[bitpos('0, msb_i)];
        end else if (st_q.busy && tick_i) begin
            st_d.sck = ~st_q.sck;
            if (cpha_i ? !lead : lead) begin
                st_d.rx[bitpos(bidx, msb_i)] = miso_i;
            end
            if (!cpha_i && !lead && !last) begin
                st_d.mosi = st_q.tx[bitpos(bidx + BIT_W'(1), msb_i)];
            end
            if (cpha_i && lead) begin
                st_d.mosi = st_q.tx[bitpos(bidx, msb_i)];
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (last) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                finish_o  = 1'b1;
            end
        end else if (!st_q.busy) begin
            st_d.sck = cpol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck_o  = st_q.sck;
    assign mosi_o = st_q.mosi;
    assign busy_o = st_q.busy;
    assign rx_o   = st_q.rx;

    // R10: the register block must never launch into a running exchange
    a_r10_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !st_q.busy);
    // R5: between rate edges the serial clock holds still
    a_r5_sck_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick_i && !start_i) |=> $stable(st_q.sck));
    // R3: an exchange only ends on a rate edge
    a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(tick_i));
    // R6: first-edge capture mode keeps MOSI steady across capturing edges
    a_r6_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && tick_i && lead && !cpha_i) |=> $stable(st_q.mosi));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          busy_i,
    input  logic          finish_i,
    input  logic [DW-1:0] rx_i,
    output logic [DW-1:0] fmt_o,
    output logic [DW-1:0] mant_o,
    output logic          start_o
);
    typedef struct packed {
        logic [DW-1:0] fmt;
        logic [DW-1:0] mant;
        logic          done;
    } reg_st_t;

    reg_st_t  st_q, st_d;
    reg_sel_e sel;
    logic     clr_req;

    always_comb begin
        sel     = reg_sel_e'(addr_i);
        st_d    = st_q;
        clr_req = wr_i && (sel == A_STAT) && !wdata_i[S_DONE];
        start_o = wr_i && (sel == A_DATA) && !busy_i;
        if (wr_i && sel == A_FMT)  st_d.fmt  = wdata_i;
        if (wr_i && sel == A_MANT) st_d.mant = wdata_i;
        if (finish_i)      st_d.done = 1'b1;
        else if (clr_req)  st_d.done = 1'b0;
        rdata_o = '0;
        case (sel)
            A_STAT: begin
                rdata_o[S_DONE] = st_q.done;
                rdata_o[S_BUSY] = busy_i;
            end
            A_FMT:   rdata_o = st_q.fmt;
            A_MANT:  rdata_o = st_q.mant;
            default: rdata_o = rx_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fmt_o  = st_q.fmt;
    assign mant_o = st_q.mant;

    // R9: completion flag rises exactly when the shifter leaves busy
    a_r9_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $fell(busy_i));
    // R9: without a clearing write the flag stays up
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clr_req) |=> st_q.done);
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    logic [DW-1:0] fmt, mant, rx;
    logic          busy, finish, start, tick;

    spim_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr),
        .wr_i     (reg_wr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .busy_i   (busy),
        .finish_i (finish),
        .rx_i     (rx),
        .fmt_o    (fmt),
        .mant_o   (mant),
        .start_o  (start)
    );

    spim_baud #(.ACC_W(ACC_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (busy),
        .clear_i (start),
        .exp_i   (fmt[EXP_W-1:0]),
        .mant_i  (mant),
        .tick_o  (tick)
    );

    spim_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tx_i     (reg_wdata),
        .tick_i   (tick),
        .cpol_i   (fmt[F_CPOL]),
        .cpha_i   (fmt[F_CPHA]),
        .msb_i    (fmt[F_MSB]),
        .miso_i   (spi_miso),
        .sck_o    (spi_sck),
        .mosi_o   (spi_mosi),
        .busy_o   (busy),
        .finish_o (finish),
        .rx_o     (rx)
    );
endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    spim_top dut (.*);

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    localparam longint FULL = 64'd1 << 28;
    bit       m_busy, m_done, m_sck, m_mosi, m_fin, m_edge, m_lead;
    bit [7:0] m_fmt, m_mant, m_rx, m_tx, o_fmt;
    int       m_cnt;
    longint   m_acc, m_inc;

    function automatic int bp(input int k, input bit msb);
        return msb ? 7 - k : k;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_sck = 0; m_mosi = 0;
            m_fmt = 0; m_mant = 0; m_rx = 0; m_tx = 0; m_cnt = 0; m_acc = 0;
        end else begin
            o_fmt  = m_fmt;
            m_fin  = 0;
            m_edge = 0;
            m_inc  = longint'(256 + int'(m_mant)) << (int'(o_fmt[4:0]) + 1);
            if (m_inc > FULL) m_inc = FULL;
            if (m_busy) begin
                m_acc += m_inc;
                if (m_acc >= FULL) begin m_acc -= FULL; m_edge = 1; end
            end
            if (m_edge) begin
                m_lead = (m_cnt % 2 == 0);
                m_sck  = !m_sck;
                if (o_fmt[6] ? !m_lead : m_lead) m_rx[bp(m_cnt / 2, o_fmt[5])] = spi_miso;
                if (!o_fmt[6] && !m_lead && m_cnt != 15) m_mosi = m_tx[bp(m_cnt / 2 + 1, o_fmt[5])];
                if (o_fmt[6] && m_lead) m_mosi = m_tx[bp(m_cnt / 2, o_fmt[5])];
                m_cnt++;
                if (m_cnt == 16) begin m_busy = 0; m_done = 1; m_fin = 1; m_cnt = 0; end
            end else if (!m_busy) begin
                m_sck = o_fmt[7];
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: if (!reg_wdata[1] && !m_fin) m_done = 0;
                    2'd1: m_fmt = reg_wdata;
                    2'd2: m_mant = reg_wdata;
                    default: if (!m_busy && !m_fin) begin
                        m_tx = reg_wdata; m_busy = 1; m_cnt = 0; m_acc = 0;
                        m_sck = o_fmt[7];
                        if (!o_fmt[6]) m_mosi = reg_wdata[bp(0, o_fmt[5])];
                    end
                endcase
            end
        end
    end

    // ---------------- emulated slave ----------------
    bit [7:0] slave_byte, cap, cur_fmt;
    bit       prev_sck;
    int       toggles;
    bit       cmp_en = 0;

    always @(negedge clk) begin
        if (m_busy) spi_miso <= slave_byte[bp(m_cnt / 2, m_fmt[5])];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison, well away from the active edge
    always @(negedge clk) begin
        bit [7:0] er;
        bit       ld;
        #2;
        if (rst_n && cmp_en) begin
            case (reg_addr)
                2'd0: er = {6'd0, m_done, m_busy};
                2'd1: er = m_fmt;
                2'd2: er = m_mant;
                default: er = m_rx;
            endcase
            chk("R5 sck vs model", int'(spi_sck), int'(m_sck));
            chk("R6 mosi vs model", int'(spi_mosi), int'(m_mosi));
            chk("R2 rdata vs model", int'(reg_rdata), int'(er));
        end
        if (spi_sck != prev_sck) begin
            toggles++;
            ld = (spi_sck != cur_fmt[7]);
            if (cur_fmt[6] ? !ld : ld)
                cap = cur_fmt[5] ? {cap[6:0], spi_mosi} : {spi_mosi, cap[7:1]};
        end
        prev_sck = spi_sck;
    end

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd(input bit [1:0] a, output bit [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #3 d = reg_rdata;
        @(negedge clk);
        reg_addr = 2'd0;
    endtask

    task automatic xfer(input bit [7:0] f, input bit [7:0] mt, input bit [7:0] tx,
                        input bit [7:0] slv, input int exp_cycles, input bit inject);
        int       n;
        bit [7:0] v;
        wr(2'd2, mt);
        wr(2'd1, f);
        cur_fmt = f; slave_byte = slv;
        repeat (2) @(negedge clk);
        #3 chk("R5 idle level", int'(spi_sck), int'(f[7]));
        cap = 0; toggles = 0;
        wr(2'd3, tx);
        n = 0;
        if (inject) begin
            wr(2'd3, ~tx);
            n = 2;
        end
        #3;
        while (reg_rdata[0]) begin
            n++;
            @(negedge clk);
            #3;
        end
        chk("R4 busy cycles", n, exp_cycles);
        chk("R3 sck transitions", toggles, 16);
        chk("R5 sck back at rest", int'(spi_sck), int'(f[7]));
        chk(f[6] ? "R7 mosi byte" : "R6 mosi byte", int'(cap), int'(tx));
        chk("R9 done set", int'(reg_rdata[1]), 1);
        rd(2'd3, v);
        chk(f[5] ? "R8 R11 rx msb-first" : "R8 R11 rx lsb-first", int'(v), int'(slv));
        if (inject) chk("R10 busy write ignored", int'(cap), int'(tx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1
        chk("R1 sck reset", int'(spi_sck), 0);
        chk("R1 mosi reset", int'(spi_mosi), 0);
        rd(2'd0, v); chk("R1 stat reset", int'(v), 0);
        rd(2'd1, v); chk("R1 fmt reset", int'(v), 0);
        rd(2'd2, v); chk("R1 mant reset", int'(v), 0);
        cmp_en = 1;
        // R2
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 fmt readback", int'(v), 8'hA5);
        wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 mant readback", int'(v), 8'h3C);
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 stat unused bits", int'(v), 0);
        // R6 R8 polarity 0 phase 0 msb-first, E=17
        xfer(8'h31, 8'h00, 8'hF0, 8'hAA, 64, 0);
        // R9 sticky flag
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R9 done holds", int'(v), 8'h02);
        wr(2'd0, 8'h02); rd(2'd0, v); chk("R9 write one keeps", int'(v), 8'h02);
        wr(2'd0, 8'h00); rd(2'd0, v); chk("R9 write zero clears", int'(v), 8'h00);
        // R7 phase 1 lsb-first, E=18
        xfer(8'h52, 8'h00, 8'h3C, 8'h96, 32, 0);
        // R5 polarity 1 phase 0 msb-first
        xfer(8'hB1, 8'h00, 8'h81, 8'h5A, 64, 0);
        // R4 saturated rate, polarity 1 phase 1 lsb-first
        xfer(8'hDB, 8'h00, 8'hA7, 8'h1E, 16, 0);
        // R4 nonzero mantissa: 3/8 edge per cycle -> 43 cycles
        xfer(8'h31, 8'h80, 8'hC3, 8'h3D, 43, 0);
        // R10 write during busy
        xfer(8'h31, 8'h00, 8'h69, 8'hE1, 64, 1);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule